// File: doc/BRIEF.md
# Multi-Mode Modulator Bitstream Receiver

This block sits on the host side of a single-bit sigma-delta modulator link. It recovers the bitstream from the serial lines in any of four link modes, which a 2-bit mode input selects. A fast local oversampling clock runs the whole block. The data line and the returned clock line first pass through a two-flop synchronizer, and every edge is then detected in the oversampling domain. Each recovered bit leaves the block on `bit_out`, together with a single-cycle `bit_valid` strobe.

The four modes recover bits as follows:
- Mode 0 and mode 3 take one bit on each rising edge of the returned clock.
- Mode 1 takes a bit on both edges of a returned clock that runs at half the bit rate.
- Mode 2 has no returned clock. The bits come from Manchester coding on the data line. A counter locks onto the mid-bit transitions, ignores the transitions at bit boundaries, and flags loss of lock when the line stays quiet too long.
- Mode 3 also needs the host to supply the modulator's system clock. The block provides a divide-by-two reference of its own clock for that purpose.

The usual bit rates lie between 0.5 and 12 Mbit/s, with 10 Mbit/s nominal. The oversampling clock must be fast enough that the parameter `OSR` covers one nominal Manchester bit period in clock cycles.

Top module: `mbs_receiver`

## Requirements
- R1: While reset is high and in the first cycle after it, `bit_valid`, `bit_out`, `lock_lost` and `ref_clk_out` are all 0.
- R2: With mode = 2'b00, exactly one bit is emitted for each rising edge of `rx_clk`. Its value is the level of `rx_data` at that edge. Falling edges emit nothing.
- R3: With mode = 2'b01, one bit is emitted on every rising edge and on every falling edge of `rx_clk`, each bit carrying the `rx_data` level at that edge.
- R4: With mode = 2'b10, a low-to-high transition in the middle of a bit decodes as 1 and a high-to-low one decodes as 0. Lock is first acquired on a transition that follows the previous one by at least 3/4 of `OSR` cycles. The bit at that transition is the first bit emitted.
- R5: With mode = 2'b10 and lock held, a transition arriving less than 3/4 of `OSR` cycles after the last accepted one is a bit-boundary transition. It emits nothing and does not disturb the bit timing, so runs of equal bits decode correctly.
- R6: Manchester decoding stays error-free when the actual bit period deviates by up to ±10% from `OSR` cycles.
- R7: With mode = 2'b10, `lock_lost` is 1 from reset until lock is first acquired. It returns to 1 when more than 2·`OSR` cycles pass without an accepted mid-bit transition, and it is 0 while lock is held.
- R8: With mode = 2'b11, bits are captured on rising edges of `rx_clk` as in R2, and `ref_clk_out` inverts on every clock cycle. In the other modes `ref_clk_out` is 0.
- R9: `bit_valid` never stays high for two consecutive cycles.
- R10: In modes other than 2'b10, `lock_lost` is 0. In mode 2'b10, `rx_clk` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Link mode: 00 rising-edge, 01 dual-edge half-rate, 10 Manchester, 11 host-clocked |
| rx_data | input | 1 | Received serial data line (asynchronous) |
| rx_clk | input | 1 | Received bit clock line (asynchronous, unused in mode 10) |
| bit_out | output | 1 | Recovered bit, held between strobes |
| bit_valid | output | 1 | One-cycle strobe per recovered bit |
| lock_lost | output | 1 | Manchester decoder not locked (mode 10 only) |
| ref_clk_out | output | 1 | Half-rate reference of `clk` in mode 11, else 0 |

## Verification
Several properties are checked on every cycle by assertions:
- `bit_valid` is a single-cycle strobe.
- Falling edges are ignored in the rising-edge modes.
- Manchester bits appear only while the decoder is locked.
- `lock_lost` and `ref_clk_out` stay low outside their own modes.
- `ref_clk_out` inverts every cycle in mode 11.

Only the directed scenarios can show the bit values and bit counts. They cover:
- correct bit sequences in each clocked mode;
- Manchester decoding across runs of equal bits at nominal, slow and fast rates;
- acquisition from an idle line;
- the timing of loss-of-lock.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [1:0] {
    MODE_RISE   = 2'b00,
    MODE_DUAL   = 2'b01,
    MODE_MANCH  = 2'b10,
    MODE_EXTCLK = 2'b11
  } rx_mode_e;
endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] lvl_dly
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
      lvl_dly <= '0;
    end else begin
      pipe[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      lvl_dly <= pipe[STAGES-1];
    end
  end

  assign lvl = pipe[STAGES-1];
endmodule

// File: rtl/mbs_edge_capture.sv
module mbs_edge_capture (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic dual,
  input  logic d,
  input  logic ck_rise,
  input  logic ck_fall,
  output logic bit_o,
  output logic valid_o
);
  logic take;
  assign take = en && (ck_rise || (dual && ck_fall));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      bit_o   <= 1'b0;
    end else begin
      valid_o <= take;
      if (take) bit_o <= d;
    end
  end

  // R2
  rise_only_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !dual && ck_fall) |=> !valid_o);
endmodule

// File: rtl/mbs_manchester.sv
module mbs_manchester #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  input  logic edge_det,
  output logic bit_o,
  output logic valid_o,
  output logic locked_o
);
  localparam int THRESH   = (3 * OSR) / 4;
  localparam int LOSS_LIM = 2 * OSR;
  localparam int SAT      = LOSS_LIM + 1;
  localparam int CW       = $clog2(LOSS_LIM + 2);

  logic [CW-1:0] cnt;
  logic          accept;

  assign accept = edge_det && (cnt >= CW'(THRESH)) && (cnt <= CW'(LOSS_LIM));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= CW'(SAT);
      locked_o <= 1'b0;
      valid_o  <= 1'b0;
      bit_o    <= 1'b0;
    end else if (!en) begin
      cnt      <= CW'(SAT);
      locked_o <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= accept;
      if (accept) begin
        bit_o    <= d;
        locked_o <= 1'b1;
        cnt      <= '0;
      end else if (edge_det && !locked_o) begin
        cnt <= '0;
      end else if (cnt != CW'(SAT)) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(LOSS_LIM)) locked_o <= 1'b0;
      end
    end
  end

  // R4
  bit_when_locked_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> locked_o);
endmodule

// File: rtl/mbs_receiver.sv
module mbs_receiver #(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       rx_data,
  input  logic       rx_clk,
  output logic       bit_out,
  output logic       bit_valid,
  output logic       lock_lost,
  output logic       ref_clk_out
);
  import mbs_pkg::*;

  rx_mode_e   m;
  logic [1:0] lvl, lvl_dly;
  logic       ck_rise, ck_fall, d_edge;
  logic       cap_bit, cap_valid, man_bit, man_valid, man_locked;
  logic       man_en;

  assign m = rx_mode_e'(mode);
  assign man_en = (m == MODE_MANCH);

  mbs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din({rx_clk, rx_data}),
    .lvl(lvl), .lvl_dly(lvl_dly)
  );

  assign ck_rise = lvl[1] & ~lvl_dly[1];
  assign ck_fall = ~lvl[1] & lvl_dly[1];
  assign d_edge  = lvl[0] ^ lvl_dly[0];

  mbs_edge_capture u_cap (
    .clk(clk), .rst(rst), .en(!man_en), .dual(m == MODE_DUAL),
    .d(lvl[0]), .ck_rise(ck_rise), .ck_fall(ck_fall),
    .bit_o(cap_bit), .valid_o(cap_valid)
  );

  mbs_manchester #(.OSR(OSR)) u_man (
    .clk(clk), .rst(rst), .en(man_en), .d(lvl[0]), .edge_det(d_edge),
    .bit_o(man_bit), .valid_o(man_valid), .locked_o(man_locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_out     <= 1'b0;
      bit_valid   <= 1'b0;
      lock_lost   <= 1'b0;
      ref_clk_out <= 1'b0;
    end else begin
      bit_valid <= man_en ? man_valid : cap_valid;
      if (man_en && man_valid) bit_out <= man_bit;
      else if (!man_en && cap_valid) bit_out <= cap_bit;
      lock_lost   <= man_en && !man_locked;
      ref_clk_out <= (m == MODE_EXTCLK) ? ~ref_clk_out : 1'b0;
    end
  end

  // R9
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);
  // R8
  ref_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b11) |=> !ref_clk_out);
  // R8
  ref_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> (ref_clk_out != $past(ref_clk_out)));
  // R10
  lock_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b10) |=> !lock_lost);
endmodule

// File: tb/mbs_receiver_test.sv
`timescale 1ns/1ps
module mbs_receiver_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       rx_data = 1'b0;
  logic       rx_clk = 1'b0;
  logic       bit_out, bit_valid, lock_lost, ref_clk_out;

  int   n_chk = 0;
  int   n_fail = 0;
  logic rec [0:255];
  int   rec_n = 0;
  int   dbl = 0;
  logic prev_v = 1'b0;

  always #2 clk = ~clk;

  mbs_receiver #(.OSR(16), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .mode(mode), .rx_data(rx_data), .rx_clk(rx_clk),
    .bit_out(bit_out), .bit_valid(bit_valid), .lock_lost(lock_lost),
    .ref_clk_out(ref_clk_out)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (bit_valid) begin
        if (rec_n < 256) rec[rec_n] = bit_out;
        rec_n++;
        if (prev_v) dbl++;
      end
      prev_v = bit_valid;
    end else prev_v = 1'b0;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] md);
    rst = 1'b1; rx_clk = 1'b0; rx_data = 1'b0; mode = md;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    rec_n = 0; dbl = 0;
  endtask

  task automatic compare_seq(string req, logic [31:0] pat, int first, int n);
    int errs = 0;
    chk({req, " bit count"}, rec_n, n - first);
    for (int i = 0; i < n - first; i++)
      if (i < rec_n && rec[i] !== pat[first + i]) errs++;
    chk({req, " bit errors"}, errs, 0);
    chk("R9 back-to-back strobes", dbl, 0);
  endtask

  task automatic send_rise(logic [31:0] pat, int n);
    for (int i = 0; i < n; i++) begin
      rx_data = pat[i];
      #40 rx_clk = 1'b1;
      #40 rx_clk = 1'b0;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic send_manch(logic [31:0] pat, int n, real half);
    for (int i = 0; i < n; i++) begin
      rx_data = ~pat[i];
      #(half);
      rx_data = pat[i];
      #(half);
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic test_reset();
    rst = 1'b1; mode = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid in reset", int'(bit_valid), 0);
    chk("R1 bit in reset", int'(bit_out), 0);
    chk("R1 ref in reset", int'(ref_clk_out), 0);
    chk("R1 lock_lost in reset", int'(lock_lost), 0);
  endtask

  task automatic test_rise();
    do_reset(2'b00);
    send_rise(32'h0000B4E1, 16);
    compare_seq("R2 rising capture", 32'h0000B4E1, 0, 16);
    chk("R8 ref low in mode 00", int'(ref_clk_out), 0);
    chk("R10 lock_lost low in mode 00", int'(lock_lost), 0);
  endtask

  task automatic test_dual();
    do_reset(2'b01);
    for (int i = 0; i < 16; i++) begin
      rx_data = 1'(32'h00006C39 >> i);
      #20 rx_clk = ~rx_clk;
      #20;
    end
    repeat (10) @(negedge clk);
    compare_seq("R3 dual-edge capture", 32'h00006C39, 0, 16);
  endtask

  task automatic test_manch(string req, real half);
    do_reset(2'b10);
    repeat (40) @(negedge clk);
    chk("R7 lock_lost before acquisition", int'(lock_lost), 1);
    send_manch(32'h009E34DA, 24, half);
    compare_seq(req, 32'h009E34DA, 1, 24);
    chk("R7 lock held after stream", int'(lock_lost), 0);
    repeat (40) @(negedge clk);
    chk("R7 lock lost after idle", int'(lock_lost), 1);
  endtask

  task automatic test_clk_ignored();
    do_reset(2'b10);
    rx_data = 1'b1;
    for (int i = 0; i < 10; i++) begin
      #40 rx_clk = 1'b1;
      #40 rx_clk = 1'b0;
    end
    repeat (10) @(negedge clk);
    chk("R10 rx_clk ignored in mode 10", rec_n, 0);
  endtask

  task automatic test_ext();
    int toggles = 0;
    logic prev;
    do_reset(2'b11);
    @(negedge clk);
    prev = ref_clk_out;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (ref_clk_out != prev) toggles++;
      prev = ref_clk_out;
    end
    chk("R8 ref toggles per cycle", toggles, 4);
    rec_n = 0; dbl = 0;
    send_rise(32'h00005A3C, 16);
    compare_seq("R8 host-clocked capture", 32'h00005A3C, 0, 16);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    test_reset();
    test_rise();
    test_dual();
    test_manch("R4 R5 Manchester nominal", 32.0);
    test_manch("R6 Manchester slow 1.1x", 35.2);
    test_manch("R6 Manchester fast 0.9x", 28.8);
    test_clk_ignored();
    test_ext();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule